// File: doc/BRIEF.md
# Programmable Threshold Flag Unit

This block produces the almost-empty, almost-full and half-full status flags for a dual-clock FIFO. It holds two offset registers. One sets how close the FIFO may come to empty before almost-empty asserts. The other sets how close it may come to full before almost-full asserts. The FIFO's memory and pointers live elsewhere. This block receives an occupancy count that has already been synchronised into each clock domain.

The loading method is chosen by a select pin sampled during master reset, and that choice also sets the default offsets. With the pin low, offsets are written from a parallel bus. With the pin high, they are shifted in one bit per write clock, least significant bit first. The method stays fixed until the next master reset. Both offsets are always visible on read-back buses. Almost-full and half-full are registered in the write-clock domain. Almost-empty passes through two registers in the read-clock domain. All flags are active low.

Top module: `thresh_flag_unit`

## Requirements
- R1: With `ofs_sel_n` low during master reset, parallel loading is selected and both offsets become 127.
- R2: With `ofs_sel_n` high during master reset, serial loading is selected and both offsets become 1023.
- R3: The loading method changes only at master reset: in parallel mode `ser_en` has no effect on the offsets, and in serial mode a parallel write has no effect.
- R4: In parallel mode, each write-clock edge with `ofs_sel_n` low and `wr_en` high stores `ofs_din`. Writes go to the almost-empty offset, then the almost-full offset, alternating. Master reset returns the target to the almost-empty offset.
- R5: In serial mode, each write-clock edge with `ser_en` high stores `ser_in` as the next offset bit, bit 0 first. The first OFS_W bits fill the almost-empty offset, the next OFS_W fill the almost-full offset, then loading wraps back to almost-empty.
- R6: `ae_ofs_q` and `af_ofs_q` show the current offsets at all times, in either mode, one write-clock edge after a load.
- R7: `af_n` is low exactly when (2^DEPTH_LOG2 − `wr_cnt`) ≤ the almost-full offset, updated one write-clock edge after `wr_cnt`.
- R8: `hf_n` is low exactly when `wr_cnt` > 2^(DEPTH_LOG2−1), updated one write-clock edge after `wr_cnt`.
- R9: `ae_n` is low exactly when `rd_cnt` ≤ the almost-empty offset. A change of `rd_cnt` reaches `ae_n` on the second read-clock edge, not the first.
- R10: While master or partial reset is low, `ae_n` is held low and `af_n` and `hf_n` are held high. Partial reset leaves the offsets, the mode and the loading position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in both domains |
| prst_n | input | 1 | Partial reset, active low; clears flags only |
| ofs_sel_n | input | 1 | Method select at master reset; parallel load strobe qualifier afterwards |
| wr_en | input | 1 | Write strobe that qualifies a parallel offset load |
| ser_en | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial offset bit |
| ofs_din | input | OFS_W | Parallel offset data |
| wr_cnt | input | DEPTH_LOG2+1 | Occupancy count in the write domain |
| rd_cnt | input | DEPTH_LOG2+1 | Occupancy count in the read domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| hf_n | output | 1 | Half-full flag, active low, write domain |
| ae_ofs_q | output | OFS_W | Almost-empty offset read-back |
| af_ofs_q | output | OFS_W | Almost-full offset read-back |

## Verification
The bench sweeps every occupancy from zero to full against fixed offsets. A comparison that is off by one, or that uses the wrong inequality, therefore shows up as a flag that flips one count too early or too late at the threshold or at the half-depth point. It loads offsets across a wrap of the alternation and of the serial bit sequence. A loader that restarts the wrong register, or reverses the bit order, gives visibly wrong read-back values. It drives the input of the unused loading method and watches the read-back for disturbance. It checks that `ae_n` is unchanged after one read edge and correct after the second. A design with a single register here, or with partial reset clearing the offsets, would fail those checks.

// File: rtl/flagu_pkg.sv
// Shared types for the threshold flag unit.
package flagu_pkg;
    // Which offset register the next load writes.
    typedef enum logic {
        TGT_AE = 1'b0,
        TGT_AF = 1'b1
    } ofs_tgt_e;
endpackage

// File: rtl/flagu_ofs_regs.sv
// Offset register file with parallel or serial loading (write clock domain).
// Assumes: mrst_n is synchronous and held low for at least one wclk edge; the
// loading method is sampled from ofs_sel_n on every reset edge and then held.
module flagu_ofs_regs #(
    parameter int OFS_W    = 10,
    parameter int DFLT_PAR = 127,
    parameter int DFLT_SER = 1023
) (
    input  logic             wclk,
    input  logic             mrst_n,
    input  logic             ofs_sel_n,
    input  logic             wr_en,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic [OFS_W-1:0] ofs_din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    import flagu_pkg::*;

    localparam int               IDX_W    = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OFS_W - 1);
    localparam logic [OFS_W-1:0] PAR_INIT = OFS_W'(DFLT_PAR);
    localparam logic [OFS_W-1:0] SER_INIT = OFS_W'(DFLT_SER);

    logic             ser_mode;
    ofs_tgt_e         tgt;
    logic [IDX_W-1:0] bit_idx;
    logic             par_wr;
    logic             ser_wr;

    assign par_wr = !ser_mode && !ofs_sel_n && wr_en;
    assign ser_wr = ser_mode && ser_en;

    // Capture the loading method while master reset is held.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            ser_mode <= ofs_sel_n;
        end
    end

    // Offset storage: default at reset, whole word or single bit afterwards.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            ae_ofs <= ofs_sel_n ? SER_INIT : PAR_INIT;
            af_ofs <= ofs_sel_n ? SER_INIT : PAR_INIT;
        end else if (par_wr) begin
            if (tgt == TGT_AE) ae_ofs <= ofs_din;
            else               af_ofs <= ofs_din;
        end else if (ser_wr) begin
            if (tgt == TGT_AE) ae_ofs[bit_idx] <= ser_in;
            else               af_ofs[bit_idx] <= ser_in;
        end
    end

    // Load sequencer: target register and serial bit position.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            tgt     <= TGT_AE;
            bit_idx <= '0;
        end else if (par_wr) begin
            tgt <= (tgt == TGT_AE) ? TGT_AF : TGT_AE;
        end else if (ser_wr) begin
            if (bit_idx == IDX_LAST) begin
                bit_idx <= '0;
                tgt     <= (tgt == TGT_AE) ? TGT_AF : TGT_AE;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // R3
    ser_blocks_par_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (ser_mode && !ofs_sel_n && wr_en && !ser_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R4
    par_alternate_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!ser_mode && !ofs_sel_n && wr_en) |=> (tgt != $past(tgt)));

    // R5
    ser_wrap_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (ser_mode && ser_en && bit_idx == IDX_LAST) |=> (tgt != $past(tgt) && bit_idx == '0));
endmodule

// File: rtl/flagu_wr_flags.sv
// Almost-full and half-full flags, registered in the write clock domain.
// Assumes: wr_cnt is already synchronous to wclk and never exceeds the depth;
// af_ofs is below the depth.
module flagu_wr_flags #(
    parameter int DEPTH_LOG2 = 10,
    parameter int OFS_W      = 10
) (
    input  logic                wclk,
    input  logic                mrst_n,
    input  logic                prst_n,
    input  logic [DEPTH_LOG2:0] wr_cnt,
    input  logic [OFS_W-1:0]    af_ofs,
    output logic                af_n,
    output logic                hf_n
);
    localparam int               CNT_W  = DEPTH_LOG2 + 1;
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(1) << DEPTH_LOG2;
    localparam logic [CNT_W-1:0] HALF_V = CNT_W'(1) << (DEPTH_LOG2 - 1);

    logic [CNT_W-1:0] free_cnt;

    assign free_cnt = FULL_V - wr_cnt;

    // Register both flags; either reset forces them inactive.
    always_ff @(posedge wclk) begin
        if (!mrst_n || !prst_n) begin
            af_n <= 1'b1;
            hf_n <= 1'b1;
        end else begin
            af_n <= !(free_cnt <= CNT_W'(af_ofs));
            hf_n <= !(wr_cnt > HALF_V);
        end
    end

    // R10
    prst_wr_flags_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !prst_n |=> (af_n && hf_n));
endmodule

// File: rtl/flagu_rd_flag.sv
// Almost-empty flag, two register stages in the read clock domain.
// Assumes: rd_cnt is synchronous to rclk; ae_ofs is quasi-static, changed only
// while the FIFO is idle, so it needs no synchroniser.
module flagu_rd_flag #(
    parameter int DEPTH_LOG2 = 10,
    parameter int OFS_W      = 10
) (
    input  logic                rclk,
    input  logic                mrst_n,
    input  logic                prst_n,
    input  logic [DEPTH_LOG2:0] rd_cnt,
    input  logic [OFS_W-1:0]    ae_ofs,
    output logic                ae_n
);
    localparam int CNT_W = DEPTH_LOG2 + 1;

    logic near_empty_q;

    // Stage 1 compares, stage 2 drives the flag pin.
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n) begin
            near_empty_q <= 1'b1;
            ae_n         <= 1'b0;
        end else begin
            near_empty_q <= (rd_cnt <= CNT_W'(ae_ofs));
            ae_n         <= !near_empty_q;
        end
    end

    // R10
    prst_rd_flag_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        !prst_n |=> !ae_n);
endmodule

// File: rtl/thresh_flag_unit.sv
// Top of the programmable threshold flag unit: offset registers in the write
// domain, almost-full and half-full in the write domain, almost-empty in the
// read domain. Assumes OFS_W <= DEPTH_LOG2 and both defaults fit in OFS_W bits.
module thresh_flag_unit #(
    parameter int DEPTH_LOG2 = 13,
    parameter int OFS_W      = 13,
    parameter int DFLT_PAR   = 127,
    parameter int DFLT_SER   = 1023
) (
    input  logic                wclk,
    input  logic                rclk,
    input  logic                mrst_n,
    input  logic                prst_n,
    input  logic                ofs_sel_n,
    input  logic                wr_en,
    input  logic                ser_en,
    input  logic                ser_in,
    input  logic [OFS_W-1:0]    ofs_din,
    input  logic [DEPTH_LOG2:0] wr_cnt,
    input  logic [DEPTH_LOG2:0] rd_cnt,
    output logic                ae_n,
    output logic                af_n,
    output logic                hf_n,
    output logic [OFS_W-1:0]    ae_ofs_q,
    output logic [OFS_W-1:0]    af_ofs_q
);
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;

    assign ae_ofs_q = ae_ofs;
    assign af_ofs_q = af_ofs;

    flagu_ofs_regs #(
        .OFS_W(OFS_W), .DFLT_PAR(DFLT_PAR), .DFLT_SER(DFLT_SER)
    ) i_ofs_regs (
        .wclk(wclk), .mrst_n(mrst_n), .ofs_sel_n(ofs_sel_n), .wr_en(wr_en),
        .ser_en(ser_en), .ser_in(ser_in), .ofs_din(ofs_din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    flagu_wr_flags #(
        .DEPTH_LOG2(DEPTH_LOG2), .OFS_W(OFS_W)
    ) i_wr_flags (
        .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_cnt(wr_cnt),
        .af_ofs(af_ofs), .af_n(af_n), .hf_n(hf_n)
    );

    flagu_rd_flag #(
        .DEPTH_LOG2(DEPTH_LOG2), .OFS_W(OFS_W)
    ) i_rd_flag (
        .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .rd_cnt(rd_cnt),
        .ae_ofs(ae_ofs), .ae_n(ae_n)
    );
endmodule

// File: tb/test_thresh_flag_unit.sv
// Self-checking bench: small configuration (depth 1024, 10-bit offsets),
// full occupancy sweeps with expected flags computed arithmetically.
module test_thresh_flag_unit;
    localparam int DL    = 10;
    localparam int OW    = 10;
    localparam int DEPTH = 1 << DL;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          ofs_sel_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          ser_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [OW-1:0] ofs_din = '0;
    logic [DL:0]   wr_cnt = '0;
    logic [DL:0]   rd_cnt = '0;
    logic          ae_n, af_n, hf_n;
    logic [OW-1:0] ae_ofs_q, af_ofs_q;

    int n_chk = 0;
    int n_bad = 0;

    thresh_flag_unit #(.DEPTH_LOG2(DL), .OFS_W(OW)) i_thresh_flag_unit (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .ofs_sel_n(ofs_sel_n), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in),
        .ofs_din(ofs_din), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
        .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n),
        .ae_ofs_q(ae_ofs_q), .af_ofs_q(af_ofs_q)
    );

    // 50 MHz write clock; read clock same rate, shifted by 7 ns.
    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_w(input int n);
        repeat (n) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic step_r(input int n);
        repeat (n) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic master_reset(input logic sel);
        @(negedge wclk);
        mrst_n    = 1'b0;
        ofs_sel_n = sel;
        step_w(4);
        mrst_n = 1'b1;
        step_w(1);
    endtask

    task automatic par_write(input int v);
        ofs_sel_n = 1'b0;
        wr_en     = 1'b1;
        ofs_din   = OW'(v);
        step_w(1);
        wr_en     = 1'b0;
    endtask

    task automatic ser_word(input int v);
        ser_en = 1'b1;
        for (int b = 0; b < OW; b++) begin
            ser_in = v[b];
            step_w(1);
        end
        ser_en = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        // Parallel mode reset.
        master_reset(1'b0);
        chk("R1 ae default", int'(ae_ofs_q), 127);
        chk("R1 af default", int'(af_ofs_q), 127);
        chk("R10 ae_n at reset", int'(ae_n), 0);
        chk("R10 af_n at reset", int'(af_n), 1);
        chk("R10 hf_n at reset", int'(hf_n), 1);

        // Parallel loads alternate AE, AF, AE.
        par_write(5);
        chk("R4 first write to ae", int'(ae_ofs_q), 5);
        chk("R6 af untouched", int'(af_ofs_q), 127);
        par_write(9);
        chk("R4 second write to af", int'(af_ofs_q), 9);
        par_write(33);
        chk("R4 wrap to ae", int'(ae_ofs_q), 33);
        chk("R4 af kept", int'(af_ofs_q), 9);
        ofs_sel_n = 1'b1;

        // Serial input ignored in parallel mode.
        ser_word(1023);
        ser_word(1023);
        chk("R3 ser ignored ae", int'(ae_ofs_q), 33);
        chk("R3 ser ignored af", int'(af_ofs_q), 9);

        // Write-domain sweep: af offset 9, half point 512.
        for (int c = 0; c <= DEPTH; c++) begin
            wr_cnt = (DL+1)'(c);
            step_w(1);
            chk("R7 af_n sweep", int'(af_n), ((DEPTH - c) <= 9) ? 0 : 1);
            chk("R8 hf_n sweep", int'(hf_n), (c > DEPTH / 2) ? 0 : 1);
        end

        // Read-domain sweep: ae offset 33, two-edge latency.
        @(negedge rclk);
        for (int c = 0; c <= DEPTH; c++) begin
            rd_cnt = (DL+1)'(c);
            step_r(2);
            chk("R9 ae_n sweep", int'(ae_n), (c <= 33) ? 0 : 1);
        end

        // Latency: unchanged after the first edge, new after the second.
        rd_cnt = 34;
        step_r(2);
        chk("R9 settled high", int'(ae_n), 1);
        rd_cnt = 0;
        step_r(1);
        chk("R9 old after one edge", int'(ae_n), 1);
        step_r(1);
        chk("R9 new after two edges", int'(ae_n), 0);

        // Partial reset forces flags, keeps offsets.
        rd_cnt = 500;
        wr_cnt = 1020;
        step_r(3);
        @(negedge wclk);
        prst_n = 1'b0;
        step_w(3);
        chk("R10 prst ae_n", int'(ae_n), 0);
        chk("R10 prst af_n", int'(af_n), 1);
        chk("R10 prst hf_n", int'(hf_n), 1);
        chk("R10 prst keeps ae", int'(ae_ofs_q), 33);
        chk("R10 prst keeps af", int'(af_ofs_q), 9);
        prst_n = 1'b1;
        step_w(3);
        chk("R7 after prst", int'(af_n), 0);
        chk("R9 after prst", int'(ae_n), 1);
        // Loader position kept: last parallel write went to ae, next goes to af.
        par_write(40);
        chk("R10 prst keeps position", int'(af_ofs_q), 40);
        ofs_sel_n = 1'b1;

        // Serial mode reset.
        wr_cnt = 0;
        rd_cnt = 0;
        master_reset(1'b1);
        chk("R2 ae default", int'(ae_ofs_q), 1023);
        chk("R2 af default", int'(af_ofs_q), 1023);

        // Serial loading, bit 0 first, AE then AF.
        ser_word(32'h2A5);
        chk("R5 ae serial", int'(ae_ofs_q), 32'h2A5);
        chk("R5 af not yet", int'(af_ofs_q), 1023);
        ser_word(32'h15A);
        chk("R5 af serial", int'(af_ofs_q), 32'h15A);

        // Serial enable low: ser_in ignored.
        ser_in = 1'b1;
        step_w(4);
        ser_in = 1'b0;
        step_w(4);
        chk("R5 idle keeps ae", int'(ae_ofs_q), 32'h2A5);

        // Parallel write ignored in serial mode.
        par_write(7);
        par_write(7);
        ofs_sel_n = 1'b1;
        chk("R3 par ignored ae", int'(ae_ofs_q), 32'h2A5);
        chk("R3 par ignored af", int'(af_ofs_q), 32'h15A);

        // Serial wraps back to AE.
        ser_word(32'h0F0);
        chk("R5 wrap to ae", int'(ae_ofs_q), 32'h0F0);
        chk("R6 af read-back", int'(af_ofs_q), 32'h15A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule